// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Buffer

The block sits behind a sample digitizer that produces one sample per clock. Every sample goes into a ring memory, so that the sample taken a programmable number of clocks in the past is always available. That number is the trigger latency. When a delayed trigger accept arrives, the block copies a fixed window of consecutive delayed samples into a free event slot. Filled slots are read out one sample per request, oldest event first.

Accepts may follow one another at any spacing, down to consecutive clocks. Each accept fills its own slot in parallel with any captures that are still running. When every slot is occupied, a further accept is refused and reported on a one-cycle overflow pulse. The consumer watches the pending-event count and the full flag. It reads a whole event by raising the read request for as many cycles as the window is long. A slot returns to the pool after its last sample has been read.

Top module: `tlp_top`

## Requirements
- R1: For an accept sampled at clock edge t with latency setting D in 1..240, word k (k = 0..11) of the event equals the sample presented at edge t - D + k.
- R2: Each stored event delivers exactly 12 words. `rd_last` is high together with the twelfth word and with no other word.
- R3: At most 8 events are held. `ev_count` gives the number of occupied slots, and `full` is high exactly when that number is 8.
- R4: An accept that arrives while 8 events are held is not stored. `overflow` is high for the one cycle after that edge, and `ev_count` stays at 8.
- R5: Events are read out in the order of their accepts. `ev_count` drops by one in the cycle after the last word of an event has been read.
- R6: Accepts spaced closer than 12 clocks, including accepts on consecutive clocks, each capture their own complete window.
- R7: A read request while no event is held, or while the oldest event is still being captured, is ignored. `rd_valid` stays low and the read position does not advance.
- R8: After reset, `ev_count` is 0, and `full`, `overflow`, `rd_valid` and `rd_last` are low.
- R9: A read request that is accepted at an edge yields `rd_valid` and `rd_data` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_in | input | 12 | Digitized sample, one per clock |
| accept | input | 1 | Delayed trigger accept, one clock per accept |
| dly | input | 8 | Trigger latency in samples, 1..240 |
| rd_req | input | 1 | Request the next word of the oldest event |
| ev_count | output | 4 | Number of events held (0..8) |
| full | output | 1 | All event slots occupied |
| overflow | output | 1 | One-cycle pulse for a refused accept |
| rd_valid | output | 1 | `rd_data` carries a word |
| rd_data | output | 12 | Event sample being read |
| rd_last | output | 1 | Final word of the event |

## Verification
The capture path is tried with single accepts at the shortest latency, a medium latency and the longest latency. The sample stream is a pattern whose values are distinct, so a window that is shifted by one sample, or a word that is swapped, is exposed. A burst of accepts on consecutive clocks shows whether captures that overlap in time keep separate contents. A burst spaced two clocks apart, filled to capacity, separates correct ordering and freeing from a queue that returns or overwrites the wrong slot. Read requests on an empty queue and on an event still being captured show that an early request moves neither data nor the read position.

// File: rtl/tlp_pkg.sv
package tlp_pkg;
    localparam int SAMPLE_W  = 12;
    localparam int MAX_DELAY = 240;
    localparam int WINDOW    = 12;
    localparam int SLOTS     = 8;
endpackage

// File: rtl/tlp_delay.sv
module tlp_delay #(
    parameter int SW = 12,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] din,
    input  logic [AW-1:0] dly,
    output logic [SW-1:0] dout
);
    localparam int DEPTH = 2 ** AW;

    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_d, wp_q;

    always_comb begin
        wp_d = wp_q + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) wp_q <= '0;
        else     wp_q <= wp_d;
    end

    always_ff @(posedge clk) begin
        mem[wp_q] <= din;
    end

    // sample written dly edges ago
    assign dout = mem[wp_q - dly];
endmodule

// File: rtl/tlp_slot.sv
module tlp_slot #(
    parameter int SW    = 12,
    parameter int WIN   = 12,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             clr,
    input  logic [SW-1:0]    din,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             ready,
    output logic [SW-1:0]    dout
);
    typedef struct packed {
        logic [WIN-1:0][SW-1:0] w;
        logic [IDX_W-1:0]       cnt;
        logic                   busy;
        logic                   rdy;
    } slot_t;

    slot_t d, q;

    always_comb begin
        d = q;
        if (clr) d.rdy = 1'b0;
        if (start) begin
            d.w[0] = din;
            d.cnt  = IDX_W'(1);
            d.busy = 1'b1;
            d.rdy  = 1'b0;
        end else if (q.busy) begin
            d.w[q.cnt] = din;
            if (q.cnt == IDX_W'(WIN - 1)) begin
                d.busy = 1'b0;
                d.rdy  = 1'b1;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign ready = q.rdy;
    assign dout  = q.w[rd_idx];
endmodule

// File: rtl/tlp_top.sv
module tlp_top
    import tlp_pkg::*;
#(
    parameter int SW    = SAMPLE_W,
    parameter int MAXD  = MAX_DELAY,
    parameter int WIN   = WINDOW,
    parameter int NSLOT = SLOTS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [SW-1:0]                 samp_in,
    input  logic                          accept,
    input  logic [$clog2(MAXD+1)-1:0]     dly,
    input  logic                          rd_req,
    output logic [$clog2(NSLOT+1)-1:0]    ev_count,
    output logic                          full,
    output logic                          overflow,
    output logic                          rd_valid,
    output logic [SW-1:0]                 rd_data,
    output logic                          rd_last
);
    localparam int AW     = $clog2(MAXD + 1);
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;
    localparam int CNT_W  = $clog2(NSLOT + 1);
    localparam int IDX_W  = $clog2(WIN);

    typedef struct packed {
        logic [SLOT_W-1:0] wr_slot;
        logic [SLOT_W-1:0] rd_slot;
        logic [IDX_W-1:0]  rd_idx;
        logic [CNT_W-1:0]  count;
        logic              ovf;
        logic              vld;
        logic [SW-1:0]     data;
        logic              last;
    } ctl_t;

    ctl_t d, q;

    logic [SW-1:0] dly_sample;
    logic [NSLOT-1:0] slot_rdy, slot_start, slot_clr;
    logic [SW-1:0] slot_dout [NSLOT];
    logic alloc, rd_go, free_slot;

    tlp_delay #(.SW(SW), .AW(AW)) u_delay (
        .clk (clk),
        .rst (rst),
        .din (samp_in),
        .dly (dly),
        .dout(dly_sample)
    );

    assign alloc     = accept && (q.count != CNT_W'(NSLOT));
    assign rd_go     = rd_req && slot_rdy[q.rd_slot];
    assign free_slot = rd_go && (q.rd_idx == IDX_W'(WIN - 1));

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        assign slot_start[i] = alloc && (q.wr_slot == SLOT_W'(i));
        assign slot_clr[i]   = free_slot && (q.rd_slot == SLOT_W'(i));

        tlp_slot #(.SW(SW), .WIN(WIN), .IDX_W(IDX_W)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .start (slot_start[i]),
            .clr   (slot_clr[i]),
            .din   (dly_sample),
            .rd_idx(q.rd_idx),
            .ready (slot_rdy[i]),
            .dout  (slot_dout[i])
        );
    end

    always_comb begin
        d      = q;
        d.ovf  = accept && !alloc;
        d.vld  = rd_go;
        d.last = free_slot;
        if (rd_go) begin
            d.data = slot_dout[q.rd_slot];
            if (free_slot) begin
                d.rd_idx  = '0;
                d.rd_slot = (q.rd_slot == SLOT_W'(NSLOT - 1)) ? '0 : q.rd_slot + SLOT_W'(1);
            end else begin
                d.rd_idx = q.rd_idx + IDX_W'(1);
            end
        end
        if (alloc) begin
            d.wr_slot = (q.wr_slot == SLOT_W'(NSLOT - 1)) ? '0 : q.wr_slot + SLOT_W'(1);
        end
        d.count = q.count + CNT_W'(alloc) - CNT_W'(free_slot);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign ev_count = q.count;
    assign full     = (q.count == CNT_W'(NSLOT));
    assign overflow = q.ovf;
    assign rd_valid = q.vld;
    assign rd_data  = q.data;
    assign rd_last  = q.last;
endmodule

// File: rtl/tlp_checker.sv
module tlp_checker #(
    parameter int NSLOT = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             accept,
    input logic             rd_req,
    input logic [CNT_W-1:0] ev_count,
    input logic             full,
    input logic             overflow,
    input logic             rd_valid,
    input logic             rd_last
);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        ev_count <= CNT_W'(NSLOT));

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        overflow |-> ($past(accept) && $past(full)));

    p_refuse_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && full && !rd_req) |=> (ev_count == CNT_W'(NSLOT)));

    p_read_latency_r9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_req));

    p_empty_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && ev_count == '0) |=> !rd_valid);

    p_last_valid_r2: assert property (@(posedge clk) disable iff (rst)
        rd_last |-> rd_valid);

    p_last_frees_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_last && !$past(accept)) |-> (ev_count == CNT_W'($past(ev_count) - 1'b1)));
endmodule

bind tlp_top tlp_checker #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u_tlp_checker (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .rd_req  (rd_req),
    .ev_count(ev_count),
    .full    (full),
    .overflow(overflow),
    .rd_valid(rd_valid),
    .rd_last (rd_last)
);

// File: tb/test_tlp_top.sv
module test_tlp_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] samp_in = '0;
    logic        accept = 1'b0;
    logic [7:0]  dly = 8'd20;
    logic        rd_req = 1'b0;
    logic [3:0]  ev_count;
    logic        full, overflow, rd_valid, rd_last;
    logic [11:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int ec = 0;
    bit done = 0;

    // reference queue of accept edges and latencies
    int mq_t [16];
    int mq_d [16];
    int mhead = 0;
    int mcount = 0;

    always #2.5 clk = ~clk;

    tlp_top i_tlp_top (
        .clk(clk), .rst(rst), .samp_in(samp_in), .accept(accept), .dly(dly),
        .rd_req(rd_req), .ev_count(ev_count), .full(full), .overflow(overflow),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
    );

    function automatic logic [11:0] gen(int n);
        return 12'((n * 37 + 5) & 32'hfff);
    endfunction

    always @(posedge clk) ec <= ec + 1;
    always @(negedge clk) samp_in <= gen(ec);

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // one accept; checks the overflow pulse of that accept (R4)
    task automatic do_accept(bit expect_ovf);
        @(negedge clk);
        accept = 1'b1;
        if (mcount < 8) begin
            mq_t[(mhead + mcount) % 16] = ec;
            mq_d[(mhead + mcount) % 16] = int'(dly);
            mcount++;
        end
        @(negedge clk);
        accept = 1'b0;
        chk(overflow == expect_ovf, "R4 overflow pulse", int'(overflow), int'(expect_ovf));
    endtask

    task automatic burst(int n, int gap);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            accept = 1'b1;
            mq_t[(mhead + mcount) % 16] = ec;
            mq_d[(mhead + mcount) % 16] = int'(dly);
            mcount++;
            for (int g = 1; g < gap; g++) begin
                @(negedge clk);
                accept = 1'b0;
            end
        end
        @(negedge clk);
        accept = 1'b0;
    endtask

    // reads the oldest event, 12 back-to-back requests (R1 R2 R5 R9)
    task automatic read_event(string tag);
        int t = mq_t[mhead];
        int dd = mq_d[mhead];
        @(negedge clk);
        rd_req = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == 11) rd_req = 1'b0;
            chk(rd_valid == 1'b1, {tag, " R9 rd_valid"}, int'(rd_valid), 1);
            chk(rd_data == gen(t - dd + k), {tag, " R1 word"}, int'(rd_data), int'(gen(t - dd + k)));
            chk(rd_last == (k == 11), {tag, " R2 rd_last"}, int'(rd_last), int'(k == 11));
        end
        mhead = (mhead + 1) % 16;
        mcount--;
        chk(ev_count == 4'(mcount), {tag, " R5 count after free"}, int'(ev_count), mcount);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(ev_count == 0, "R8 count", int'(ev_count), 0);
        chk(full == 0 && overflow == 0, "R8 flags", int'({full, overflow}), 0);
        chk(rd_valid == 0 && rd_last == 0, "R8 read outputs", int'({rd_valid, rd_last}), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (300) @(negedge clk);
    endtask

    task automatic t_single(int d);
        dly = 8'(d);
        do_accept(1'b0);
        repeat (14) @(negedge clk);
        chk(ev_count == 1, "R3 one event held", int'(ev_count), 1);
        read_event("single");
    endtask

    task automatic t_empty_read();
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid == 0, "R7 empty read ignored", int'(rd_valid), 0);
        dly = 8'd30;
        do_accept(1'b0);
        rd_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(rd_valid == 0, "R7 capturing read ignored", int'(rd_valid), 0);
        end
        rd_req = 1'b0;
        repeat (14) @(negedge clk);
        read_event("R7 after early request");
    endtask

    task automatic t_consecutive();
        dly = 8'd50;
        burst(4, 1);
        repeat (16) @(negedge clk);
        chk(ev_count == 4, "R6 four held", int'(ev_count), 4);
        for (int e = 0; e < 4; e++) read_event("R6 consecutive");
    endtask

    task automatic t_fill();
        dly = 8'd100;
        burst(8, 2);
        repeat (16) @(negedge clk);
        chk(ev_count == 8, "R3 eight held", int'(ev_count), 8);
        chk(full == 1, "R3 full", int'(full), 1);
        do_accept(1'b1);
        chk(ev_count == 8, "R4 count unchanged", int'(ev_count), 8);
        @(negedge clk);
        chk(overflow == 0, "R4 pulse one cycle", int'(overflow), 0);
        read_event("R5 fifo first");
        chk(full == 0, "R3 full drops", int'(full), 0);
        for (int e = 0; e < 7; e++) read_event("R5 fifo");
        chk(ev_count == 0, "R5 drained", int'(ev_count), 0);
    endtask

    initial begin
        t_reset();
        t_single(20);
        t_single(1);
        t_single(240);
        t_empty_read();
        t_consecutive();
        t_fill();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end
endmodule